// File: doc/BRIEF.md
# Region Access Guard with Tamper Lockout

This block sits beside the load/store path of a small processor whose instruction encoding is scrambled. Every data access, every port transfer and every branch operand access is presented to it together with its kind and address. It sorts the address into one of three internal regions (general-purpose, border, peripheral I/O). It then grants or refuses the access according to a kind-dependent policy: scrambled loads and stores may not reach peripheral I/O, and the plain port and branch instructions may not reach general-purpose space.

The block owns the three border registers that the plain instructions use implicitly: a transfer register for port moves, and two compare operands whose equality drives the branch unit directly. It also owns a link register that only call can write and only return can read. Every refused access, and every trap request raised by the decoder, counts as one attack attempt. A three-state monitor moves from ARMED to ALERT on the first attempt and to LOCKED when the count reaches a parameter. LOCKED is left only through reset, and while in it the block refuses everything and tells the decoder to issue no-ops.

Top module: `tamper_guard`

## Requirements
- R1: After reset all three border registers and the link register hold zero, `cmp_equal` is 1, `disabled` is 0 and the monitor is ARMED with a zero attempt count.
- R2: An address below `BC_BASE` (default 0x8000) is general-purpose, an address from `BC_BASE` up to `IO_BASE-1` (default 0x800F) is border, and an address at or above `IO_BASE` (default 0x8010) is peripheral I/O.
- R3: Kind codes 0 (load) and 1 (store) are allowed in general-purpose and border space and denied in peripheral I/O. `acc_allow` and `acc_deny` are combinational, mutually exclusive and both low without `acc_valid`.
- R4: Kind codes 2 (port-in), 3 (port-out) and 4 (branch operand) are allowed in border and peripheral I/O space and denied in general-purpose space.
- R5: Border offsets 0, 1 and 2 hold the transfer register, compare operand A and compare operand B. An allowed store to one writes `acc_wdata` at the next edge. An allowed load presents its value on `acc_rdata` in the same cycle. Any other allowed load reads zero.
- R6: An allowed port-in loads the transfer register from `acc_wdata` for an I/O address, or from the addressed border register for a border address (zero if unmapped). An allowed port-out drives the transfer register on `acc_rdata` and, when it targets border offset 1 or 2, copies it into that register.
- R7: `cmp_equal` is 1 exactly when compare operands A and B are equal, with no cycle of delay after they change.
- R8: Kind 5 (call) and kind 6 (return) ignore the address and are always allowed while unlocked. Call writes `acc_wdata` into the link register, and an allowed return shows the link register on `ret_addr`. `ret_addr` is zero in every other cycle.
- R9: A denied access changes no register and drives zero on `acc_rdata`.
- R10: Each cycle with a denied access or with `dec_trap` high counts one attempt. The monitor enters ALERT on the first attempt and LOCKED when the count reaches `TRAP_LIMIT` (default 3), and `disabled` rises in the cycle after that edge. Kind code 7 is reserved and is always denied.
- R11: Once `disabled` is high it stays high until reset. Every valid access is denied, no register changes, `acc_rdata` and `ret_addr` stay zero, and further traps have no visible effect.
- R12: `dec_trap` counts even when no access is valid. A trap in the same cycle as a denied access counts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 3 | Access kind code (0 load … 7 reserved) |
| acc_addr | input | ADDR_W | Internal address of the access |
| acc_wdata | input | DATA_W | Store data, port-in return data or call return address |
| dec_trap | input | 1 | Trap request from the decoder (reserved opcode, malformed operand) |
| acc_allow | output | 1 | Access granted |
| acc_deny | output | 1 | Access refused |
| acc_rdata | output | DATA_W | Border load data, or transfer register on port-out |
| ret_addr | output | DATA_W | Link register during an allowed return, else zero |
| xfer_reg | output | DATA_W | Transfer register value |
| cmp_a_reg | output | DATA_W | Compare operand A value |
| cmp_b_reg | output | DATA_W | Compare operand B value |
| cmp_equal | output | 1 | Operand A equals operand B |
| disabled | output | 1 | Sticky lockout: decoder must issue no-ops |

## Verification
The hardest situation to reach from the ports is the LOCKED state, entered through a particular mix of counted events. That mix includes traps with no access present and traps that coincide with a refused access, where the count must not advance twice. The directed part of the stimulus walks through those combinations one at a time just below the limit. The random part restarts from reset many times and biases addresses toward region edges and border offsets, so that lockout is reached along many different paths and the refusal of all later accesses is observed after each.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic [2:0] {
        K_LOAD     = 3'd0,
        K_STORE    = 3'd1,
        K_PORT_IN  = 3'd2,
        K_PORT_OUT = 3'd3,
        K_BRANCH   = 3'd4,
        K_CALL     = 3'd5,
        K_RETURN   = 3'd6,
        K_RSVD     = 3'd7
    } acc_kind_e;

    typedef enum logic [1:0] {
        RGN_GP = 2'd0,
        RGN_BC = 2'd1,
        RGN_IO = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        MON_ARMED  = 2'd0,
        MON_ALERT  = 2'd1,
        MON_LOCKED = 2'd2
    } mon_state_e;

    // border slots: 0 transfer, 1 compare A, 2 compare B
    localparam int unsigned SLOTS = 3;

endpackage

// File: rtl/tg_region.sv
module tg_region
    import tg_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BC_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'h8010
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn,
    output logic [SLOTS-1:0]  slot_sel
);

    always_comb begin
        if (addr < BC_BASE)      rgn = RGN_GP;
        else if (addr < IO_BASE) rgn = RGN_BC;
        else                     rgn = RGN_IO;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign slot_sel[k] = (addr == BC_BASE + ADDR_W'(k));
    end

endmodule

// File: rtl/tg_policy.sv
module tg_policy
    import tg_pkg::*;
(
    input  acc_kind_e kind,
    input  region_e   rgn,
    output logic      legal
);

    always_comb begin
        unique case (kind)
            K_LOAD, K_STORE:                  legal = (rgn != RGN_IO);
            K_PORT_IN, K_PORT_OUT, K_BRANCH:  legal = (rgn != RGN_GP);
            K_CALL, K_RETURN:                 legal = 1'b1;
            default:                          legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/tg_iface_regs.sv
module tg_iface_regs
    import tg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  acc_kind_e         kind,
    input  region_e           rgn,
    input  logic [SLOTS-1:0]  slot_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] slot_rd,
    output logic [DATA_W-1:0] xfer_q,
    output logic [DATA_W-1:0] cmpa_q,
    output logic [DATA_W-1:0] cmpb_q,
    output logic [DATA_W-1:0] link_q
);

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [DATA_W-1:0] rd_part [SLOTS];

    // read mux: one-hot select ORed together
    for (genvar k = 0; k < SLOTS; k++) begin : g_rd
        if (k == 0) begin : g_first
            assign rd_part[k] = slot_sel[k] ? slot_q[k] : '0;
        end else begin : g_rest
            assign rd_part[k] = rd_part[k-1] | (slot_sel[k] ? slot_q[k] : '0);
        end
    end
    assign slot_rd = rd_part[SLOTS-1];

    for (genvar k = 0; k < SLOTS; k++) begin : g_reg
        logic              wr_k;
        logic [DATA_W-1:0] nxt_k;
        always_comb begin
            wr_k  = 1'b0;
            nxt_k = slot_q[k];
            if (wr_en) begin
                unique case (kind)
                    K_STORE: begin
                        wr_k  = slot_sel[k];
                        nxt_k = wdata;
                    end
                    K_PORT_OUT: begin
                        wr_k  = slot_sel[k];
                        nxt_k = slot_q[0];
                    end
                    K_PORT_IN: begin
                        wr_k  = (k == 0);
                        nxt_k = (rgn == RGN_BC) ? slot_rd : wdata;
                    end
                    default: begin
                        wr_k  = 1'b0;
                        nxt_k = slot_q[k];
                    end
                endcase
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    slot_q[k] <= '0;
            else if (wr_k) slot_q[k] <= nxt_k;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         link_q <= '0;
        else if (wr_en && kind == K_CALL)   link_q <= wdata;
    end

    assign xfer_q = slot_q[0];
    assign cmpa_q = slot_q[1];
    assign cmpb_q = slot_q[2];

endmodule

// File: rtl/tg_tamper.sv
module tg_tamper
    import tg_pkg::*;
#(
    parameter int unsigned TRAP_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic locked
);

    localparam int unsigned CNT_W = $clog2(TRAP_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(TRAP_LIMIT);

    mon_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             reach;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign reach   = (cnt_inc >= LIMIT_C);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (hit && state_q != MON_LOCKED) cnt_q <= cnt_inc;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_ARMED:  if (hit) state_d = reach ? MON_LOCKED : MON_ALERT;
            MON_ALERT:  if (hit && reach) state_d = MON_LOCKED;
            MON_LOCKED: state_d = MON_LOCKED;
            default:    state_d = MON_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MON_ARMED, MON_ALERT: locked = 1'b0;
            default:              locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tg_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] BC_BASE    = 16'h8000,
    parameter logic [ADDR_W-1:0] IO_BASE    = 16'h8010,
    parameter int unsigned       TRAP_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [2:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              dec_trap,
    output logic              acc_allow,
    output logic              acc_deny,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [DATA_W-1:0] ret_addr,
    output logic [DATA_W-1:0] xfer_reg,
    output logic [DATA_W-1:0] cmp_a_reg,
    output logic [DATA_W-1:0] cmp_b_reg,
    output logic              cmp_equal,
    output logic              disabled
);

    acc_kind_e         kind;
    region_e           rgn;
    logic [SLOTS-1:0]  slot_sel;
    logic              legal;
    logic              locked;
    logic [DATA_W-1:0] slot_rd;
    logic [DATA_W-1:0] link_q;

    assign kind = acc_kind_e'(acc_kind);

    tg_region #(
        .ADDR_W (ADDR_W),
        .BC_BASE(BC_BASE),
        .IO_BASE(IO_BASE)
    ) u_region (
        .addr    (acc_addr),
        .rgn     (rgn),
        .slot_sel(slot_sel)
    );

    tg_policy u_policy (
        .kind (kind),
        .rgn  (rgn),
        .legal(legal)
    );

    assign acc_allow = acc_valid && legal && !locked;
    assign acc_deny  = acc_valid && !acc_allow;

    tg_iface_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_allow),
        .kind    (kind),
        .rgn     (rgn),
        .slot_sel(slot_sel),
        .wdata   (acc_wdata),
        .slot_rd (slot_rd),
        .xfer_q  (xfer_reg),
        .cmpa_q  (cmp_a_reg),
        .cmpb_q  (cmp_b_reg),
        .link_q  (link_q)
    );

    tg_tamper #(
        .TRAP_LIMIT(TRAP_LIMIT)
    ) u_tamper (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (acc_deny || dec_trap),
        .locked(locked)
    );

    always_comb begin
        acc_rdata = '0;
        ret_addr  = '0;
        if (acc_allow) begin
            unique case (kind)
                K_LOAD:     acc_rdata = slot_rd;
                K_PORT_OUT: acc_rdata = xfer_reg;
                K_RETURN:   ret_addr  = link_q;
                default:    acc_rdata = '0;
            endcase
        end
    end

    assign cmp_equal = (cmp_a_reg == cmp_b_reg);
    assign disabled  = locked;

endmodule

// File: rtl/tg_guard_chk.sv
module tg_guard_chk #(
    parameter int unsigned       ADDR_W  = 16,
    parameter int unsigned       DATA_W  = 32,
    parameter logic [ADDR_W-1:0] BC_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'h8010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [2:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              dec_trap,
    input logic              acc_allow,
    input logic              acc_deny,
    input logic [DATA_W-1:0] ret_addr,
    input logic [DATA_W-1:0] xfer_reg,
    input logic [DATA_W-1:0] cmp_a_reg,
    input logic [DATA_W-1:0] cmp_b_reg,
    input logic              disabled
);

    p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_allow != acc_deny));

    p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_allow && !acc_deny));

    p_io_from_scrambled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind <= 3'd1 && acc_addr >= IO_BASE) |-> acc_deny);

    p_gp_from_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind >= 3'd2 && acc_kind <= 3'd4 && acc_addr < BC_BASE) |-> acc_deny);

    p_ret_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_kind == 3'd6) |-> (ret_addr == '0));

    p_deny_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_deny |=> ($stable(xfer_reg) && $stable(cmp_a_reg) && $stable(cmp_b_reg)));

    p_lock_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disabled) |-> $past(acc_deny || dec_trap));

    p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        disabled |=> disabled);

    p_lock_refuses_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (disabled && acc_valid) |-> acc_deny);

endmodule

bind tamper_guard tg_guard_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BC_BASE(BC_BASE),
    .IO_BASE(IO_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_kind (acc_kind),
    .acc_addr (acc_addr),
    .dec_trap (dec_trap),
    .acc_allow(acc_allow),
    .acc_deny (acc_deny),
    .ret_addr (ret_addr),
    .xfer_reg (xfer_reg),
    .cmp_a_reg(cmp_a_reg),
    .cmp_b_reg(cmp_b_reg),
    .disabled (disabled)
);

// File: tb/tamper_guard_test.sv
module tamper_guard_test;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 32;
    localparam logic [AW-1:0] BCB = 16'h8000;
    localparam logic [AW-1:0] IOB = 16'h8010;
    localparam int LIMIT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [2:0]    acc_kind = 3'd0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic          dec_trap = 1'b0;
    logic          acc_allow, acc_deny, cmp_equal, disabled;
    logic [DW-1:0] acc_rdata, ret_addr, xfer_reg, cmp_a_reg, cmp_b_reg;

    int n_run = 0;
    int n_fail = 0;

    // bench model
    logic [DW-1:0] m_slot [3];
    logic [DW-1:0] m_link;
    int            m_cnt;
    bit            m_locked;

    always #10 clk = ~clk;

    tamper_guard #(
        .ADDR_W(AW), .DATA_W(DW), .BC_BASE(BCB), .IO_BASE(IOB), .TRAP_LIMIT(LIMIT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .dec_trap(dec_trap),
        .acc_allow(acc_allow), .acc_deny(acc_deny), .acc_rdata(acc_rdata),
        .ret_addr(ret_addr), .xfer_reg(xfer_reg), .cmp_a_reg(cmp_a_reg),
        .cmp_b_reg(cmp_b_reg), .cmp_equal(cmp_equal), .disabled(disabled)
    );

    task automatic chk(bit ok, string tag, string note, string what,
                       logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %h expected %h", tag, note, what, act, exp);
        end
    endtask

    // R2: region from address; 0 GP, 1 border, 2 I/O
    function automatic int rgn_of(logic [AW-1:0] a);
        if (a < BCB) return 0;
        if (a < IOB) return 1;
        return 2;
    endfunction

    function automatic bit legal_of(int k, int r);
        if (k <= 1) return r != 2;
        if (k <= 4) return r != 0;
        if (k <= 6) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int slot_of(logic [AW-1:0] a);
        if (a >= BCB && a < BCB + 16'd3) return int'(a - BCB);
        return -1;
    endfunction

    function automatic string kind_tag(int k);
        if (k <= 1) return "R3";
        if (k <= 4) return "R4";
        if (k <= 6) return "R8";
        return "R10";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) m_slot[i] = '0;
        m_link = '0;
        m_cnt = 0;
        m_locked = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        dec_trap = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_acc(bit v, int k, logic [AW-1:0] a, logic [DW-1:0] wd,
                          bit trap, string note);
        int r, s;
        bit lg, e_allow;
        logic [DW-1:0] e_rd, e_ret, src;
        @(negedge clk);
        acc_valid = v;
        acc_kind  = 3'(k);
        acc_addr  = a;
        acc_wdata = wd;
        dec_trap  = trap;
        #5;
        r = rgn_of(a);
        s = slot_of(a);
        lg = legal_of(k, r);
        e_allow = v && lg && !m_locked;
        e_rd = '0;
        e_ret = '0;
        if (e_allow && k == 0) e_rd = (s >= 0) ? m_slot[s] : '0;
        if (e_allow && k == 3) e_rd = m_slot[0];
        if (e_allow && k == 6) e_ret = m_link;
        // register state before this edge
        chk(xfer_reg == m_slot[0], "R9", note, "xfer_reg", xfer_reg, m_slot[0]);
        chk(cmp_a_reg == m_slot[1], "R5", note, "cmp_a_reg", cmp_a_reg, m_slot[1]);
        chk(cmp_b_reg == m_slot[2], "R6", note, "cmp_b_reg", cmp_b_reg, m_slot[2]);
        chk(cmp_equal == (m_slot[1] == m_slot[2]), "R7", note, "cmp_equal",
            DW'(cmp_equal), DW'(m_slot[1] == m_slot[2]));
        chk(disabled == m_locked, m_locked ? "R11" : "R10", note, "disabled",
            DW'(disabled), DW'(m_locked));
        chk(acc_allow == e_allow, m_locked ? "R11" : kind_tag(k), note, "acc_allow",
            DW'(acc_allow), DW'(e_allow));
        chk(acc_deny == (v && !e_allow), "R3", note, "acc_deny",
            DW'(acc_deny), DW'(v && !e_allow));
        chk(acc_rdata == e_rd, (k == 3) ? "R6" : "R5", note, "acc_rdata", acc_rdata, e_rd);
        chk(ret_addr == e_ret, "R8", note, "ret_addr", ret_addr, e_ret);
        // model update at the coming edge
        if (e_allow) begin
            case (k)
                1: if (s >= 0) m_slot[s] = wd;
                2: begin
                    src = (r == 1) ? ((s >= 0) ? m_slot[s] : '0) : wd;
                    m_slot[0] = src;
                end
                3: if (s >= 0) m_slot[s] = m_slot[0];
                5: m_link = wd;
                default: ;
            endcase
        end
        if (!m_locked && ((v && !lg) || trap)) begin
            m_cnt++;
            if (m_cnt >= LIMIT) m_locked = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        do_reset();

        do_acc(0, 0, 16'h0, 32'h0, 0, "R1 reset state");
        // border registers
        do_acc(1, 1, BCB + 16'd1, 32'h11, 0, "R5 store cmpA");
        do_acc(1, 1, BCB + 16'd2, 32'h11, 0, "R7 store cmpB equal");
        do_acc(0, 0, 16'h0, 32'h0, 0, "R7 equal seen");
        do_acc(1, 1, BCB + 16'd2, 32'h22, 0, "R7 store cmpB differ");
        do_acc(1, 0, BCB + 16'd1, 32'h0, 0, "R5 load cmpA");
        do_acc(1, 0, BCB + 16'd7, 32'h0, 0, "R5 load unmapped border");
        // region edges
        do_acc(1, 0, BCB - 16'd1, 32'h0, 0, "R2 last GP address");
        do_acc(1, 1, IOB - 16'd1, 32'h55, 0, "R2 last border address");
        do_acc(1, 2, IOB, 32'hCAFE, 0, "R2 first I/O address port-in");
        // port moves
        do_acc(1, 3, BCB + 16'd1, 32'h0, 0, "R6 port-out into cmpA");
        do_acc(1, 3, IOB + 16'd4, 32'h0, 0, "R6 port-out to I/O");
        do_acc(1, 2, BCB + 16'd2, 32'h0, 0, "R6 port-in from cmpB");
        do_acc(1, 2, BCB + 16'd5, 32'h0, 0, "R6 port-in from unmapped border");
        // link register
        do_acc(1, 5, 16'h0123, 32'h1234, 0, "R8 call");
        do_acc(1, 6, 16'hFFFF, 32'h0, 0, "R8 return");
        do_acc(1, 0, 16'h0010, 32'h0, 0, "R8 no return");
        do_acc(1, 4, BCB, 32'h0, 0, "R4 branch border");
        do_acc(1, 4, IOB + 16'd9, 32'h0, 0, "R4 branch I/O");
        // refusals below the limit
        do_acc(1, 1, IOB, 32'hDEAD, 0, "R9 store to I/O");
        do_acc(1, 2, 16'h0004, 32'hBEEF, 0, "R9 port-in from GP");
        do_acc(0, 0, 16'h0, 32'h0, 0, "R10 alert not locked");

        do_reset();
        do_acc(0, 0, 16'h0, 32'h0, 1, "R12 trap without access");
        do_acc(1, 3, 16'h0020, 32'h0, 1, "R12 trap with refusal counts once");
        do_acc(0, 0, 16'h0, 32'h0, 0, "R12 still unlocked");
        do_acc(1, 1, BCB + 16'd1, 32'h77, 1, "R10 third attempt locks");
        do_acc(1, 1, BCB + 16'd1, 32'h99, 0, "R11 store refused");
        do_acc(1, 6, 16'h0, 32'h0, 1, "R11 return refused");
        do_acc(1, 0, BCB + 16'd1, 32'h0, 0, "R11 load refused");

        do_reset();
        do_acc(0, 0, 16'h0, 32'h0, 0, "R1 reset clears lock");
        do_acc(1, 7, BCB, 32'h0, 0, "R10 reserved kind");
        do_acc(1, 7, 16'h0, 32'h0, 0, "R10 reserved kind");
        do_acc(1, 7, IOB, 32'h0, 0, "R10 reserved kind locks");
        do_acc(1, 0, 16'h0, 32'h0, 0, "R11 locked");

        // random phase
        for (int b = 0; b < 60; b++) begin
            do_reset();
            for (int j = 0; j < 30; j++) begin
                int k, rs;
                logic [AW-1:0] a;
                k = int'($urandom % 7);
                if ($urandom % 25 == 0) k = 7;
                rs = int'($urandom % 8);
                if (rs < 2)      a = AW'($urandom % 32'(BCB));
                else if (rs < 6) a = BCB + AW'($urandom % 4);
                else if (rs < 7) a = IOB - AW'(1) + AW'($urandom % 3);
                else             a = IOB + AW'($urandom % 256);
                do_acc(($urandom % 8) != 0, k, a, $urandom, ($urandom % 20) == 0,
                       "random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule